// File: doc/BRIEF.md
# Codeword-Aligned 640-to-680 Word Repacker

This block takes a stream of 640-bit words and repacks it into 680-bit words. In a receive path it sits between lane deskew and a Reed-Solomon decoder. One 5440-bit codeword covers 8.5 input words but exactly eight output words, so the decoder can work on whole output words. Every input word is 16 lanes of 40 bits, which is 64 symbols of 10 bits. Every output word is 68 symbols. Symbols pass through in order; none is reordered, dropped or duplicated.

The start-of-codeword marker always arrives on an input-word boundary. When it arrives, the block re-aligns to it. Codewords then alternate between starting on a word boundary and starting 320 bits into a word. The block finds each of those mid-word starts by counting bits; it needs no extra marker for them.

Both sides share one clock. The lower average input rate is modelled by leaving `in_valid` low on some cycles. Because the output word is wider than the input word, the leftover bits never reach a full output word. At most one output word is produced per clock.

Top module: `cw_repack640to680`

## Requirements
- R1: After reset, `out_valid` and `out_first` are low and `out_data` is zero. The leftover-bit store is empty and the codeword phase is zero.
- R2: Valid input words are discarded and produce no output until the first valid word that has `in_sop` high.
- R3: Symbol order is kept. Symbol k of a word sits in bits [10k+9:10k], with k=0 first in the stream. Output word n after a start marker carries stream symbols 68n to 68n+67, counting from symbol 0 of the marked word.
- R4: `out_first` is high on output words 0, 8, 16, ... counted from the last start marker, and low on every other valid output word.
- R5: Starting with a marked word, every 17 valid input words produce exactly 16 valid output words. An output word appears one cycle after the input word that completes it.
- R6: A cycle with `in_valid` low adds no data, produces no output and leaves the stored bits unchanged.
- R7: A valid word with `in_sop` high drops any stored leftover bits and restarts the codeword phase at zero. It then counts as symbol 0 of a new codeword.
- R8: `out_valid` is raised only when a full 680-bit word is available. Fewer than 680 leftover bits are held between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 640 | Input word, symbol 0 in the low bits |
| in_valid | input | 1 | Input word is present |
| in_sop | input | 1 | Input word starts a codeword (qualified by in_valid) |
| out_data | output | 680 | Output word, symbol 0 in the low bits |
| out_valid | output | 1 | Output word is present |
| out_first | output | 1 | Output word is the first of a codeword |

## Verification
The bench uses the default widths: 640 in, 680 out, 10-bit symbols, eight output words per codeword. With these widths the leftover count visits all 17 multiples of 40 between 0 and 640. A stream of 34 words therefore covers both the word-edge and the mid-word codeword start. Idle cycles placed at different fill levels show that the stored bits wait unchanged. A start marker sent in the middle of a codeword shows that the leftover bits are dropped when the block re-aligns.

// File: rtl/cw_repack640to680.sv
module cw_repack640to680 #(
  parameter int IN_W     = 640,
  parameter int OUT_W    = 680,
  parameter int CW_WORDS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  in_data,
  input  logic             in_valid,
  input  logic             in_sop,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  output logic             out_first
);

  localparam int BUF_W = IN_W + OUT_W;
  localparam int FW    = $clog2(BUF_W + 1);
  localparam int PW    = (CW_WORDS > 1) ? $clog2(CW_WORDS) : 1;
  localparam logic [FW-1:0] OUT_WF = FW'(OUT_W);
  localparam logic [FW-1:0] IN_WF  = FW'(IN_W);
  localparam logic [PW-1:0] LAST_PH = PW'(CW_WORDS - 1);

  logic [OUT_W-1:0] residue;
  logic [FW-1:0]    fill;
  logic [PW-1:0]    phase;
  logic             locked;

  logic             take, emit;
  logic [FW-1:0]    base_fill, tot;
  logic [PW-1:0]    base_phase;
  logic [BUF_W-1:0] merged;

  assign take       = in_valid && (locked || in_sop);
  assign base_fill  = in_sop ? '0 : fill;
  assign base_phase = in_sop ? '0 : phase;
  assign tot        = base_fill + IN_WF;
  assign emit       = take && (tot >= OUT_WF);
  assign merged     = {{IN_W{1'b0}}, (in_sop ? {OUT_W{1'b0}} : residue)}
                    | ({{OUT_W{1'b0}}, in_data} << base_fill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      residue   <= '0;
      fill      <= '0;
      phase     <= '0;
      locked    <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else begin
      out_valid <= emit;
      out_first <= emit && (base_phase == '0);
      if (take) begin
        locked <= 1'b1;
        if (emit) begin
          out_data <= merged[OUT_W-1:0];
          residue  <= OUT_W'(merged[BUF_W-1:OUT_W]);
          fill     <= tot - OUT_WF;
          phase    <= (base_phase == LAST_PH) ? '0 : base_phase + 1'b1;
        end else begin
          residue  <= merged[OUT_W-1:0];
          fill     <= tot;
          phase    <= base_phase;
        end
      end
    end
  end

endmodule

module cw_repack640to680_chk #(
  parameter int IN_W  = 640,
  parameter int OUT_W = 680,
  parameter int FW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sop,
  input logic          out_valid,
  input logic          out_first,
  input logic          locked,
  input logic [FW-1:0] fill
);

  localparam logic [FW-1:0] OUT_WF = FW'(OUT_W);
  localparam logic [FW-1:0] GAP    = FW'(OUT_W - IN_W);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill < OUT_WF);

  assert_first_is_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  assert_discard_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !out_valid);

  assert_output_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_full_word_emits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && locked && fill >= GAP) |=> out_valid);

  assert_sop_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> !out_valid);

endmodule

bind cw_repack640to680 cw_repack640to680_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
  .out_valid(out_valid), .out_first(out_first), .locked(locked), .fill(fill)
);

// File: tb/tb_cw_repack640to680.sv
module tb_cw_repack640to680;
  localparam int IN_W = 640, OUT_W = 680, SYM = 10, CWW = 8;
  localparam int NI = IN_W / SYM, NO = OUT_W / SYM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [OUT_W-1:0] out_data;
  logic out_valid, out_first;

  always #4 clk = ~clk;

  cw_repack640to680 dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_sop(in_sop), .out_data(out_data), .out_valid(out_valid),
    .out_first(out_first)
  );

  int errors = 0, checks = 0, n_out = 0, cycles = 0;
  int seq = 0;
  int q[$];
  bit m_lock = 0;
  int m_phase = 0;
  bit e_valid = 0, e_first = 0;
  logic [OUT_W-1:0] e_data = '0;
  string cur_req = "R5";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit s);
    in_valid = v;
    in_sop   = s;
    for (int j = 0; j < NI; j++) in_data[j*SYM +: SYM] = SYM'((seq + j) % 1024);
    @(posedge clk);
    e_valid = 0;
    e_first = 0;
    if (v && (m_lock || s)) begin
      if (s) begin q.delete(); m_lock = 1; m_phase = 0; end
      for (int j = 0; j < NI; j++) q.push_back((seq + j) % 1024);
      if (q.size() >= NO) begin
        e_valid = 1;
        e_first = (m_phase == 0);
        for (int j = 0; j < NO; j++) e_data[j*SYM +: SYM] = SYM'(q.pop_front());
        m_phase = (m_phase + 1) % CWW;
      end
    end
    if (v) seq += NI;
    @(negedge clk);
    check(out_valid == e_valid, cur_req, "out_valid", OUT_W'(out_valid), OUT_W'(e_valid));
    check(out_first == e_first, "R4", "out_first", OUT_W'(out_first), OUT_W'(e_first));
    if (e_valid && out_valid)
      check(out_data == e_data, "R3", "out_data", out_data, e_data);
    if (out_valid) n_out++;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_first == 1'b0 && out_data == '0, "R1",
          "reset outputs", {out_data[OUT_W-3:0], out_valid, out_first}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R2";
    for (int i = 0; i < 5; i++) step(1, 0);
    check(n_out == 0, "R2", "outputs before first marker", OUT_W'(n_out), '0);

    cur_req = "R5";
    base = n_out;
    for (int i = 0; i < 17; i++) step(1, i == 0);
    check(n_out - base == 16, "R5", "17 in to 16 out", OUT_W'(n_out - base), OUT_W'(16));
    for (int i = 0; i < 17; i++) step(1, i == 0);

    cur_req = "R6";
    base = n_out;
    for (int i = 0; i < 34; i++) begin
      step(1, (i % 17) == 0);
      if ((i % 3) == 1) step(0, 0);
      if ((i % 5) == 2) begin step(0, 1); step(0, 0); end
    end
    check(n_out - base == 32, "R6", "idle cycles keep ratio", OUT_W'(n_out - base), OUT_W'(32));

    cur_req = "R7";
    for (int i = 0; i < 5; i++) step(1, 0);
    base = n_out;
    for (int i = 0; i < 17; i++) step(1, i == 0);
    check(n_out - base == 16, "R7", "resync ratio", OUT_W'(n_out - base), OUT_W'(16));

    cur_req = "R8";
    for (int i = 0; i < 3; i++) step(1, 0);
    step(0, 0);
    step(1, 1);
    step(0, 0);
    for (int i = 0; i < 8; i++) step(1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule